// File: doc/BRIEF.md
# Hierarchical Reset Sequencer

This block produces the three nested active-low resets of a processor subsystem: power-on, hard and soft. A supervisor's power-good flag holds power-on reset and stretches it for a set number of clocks. A fixed count of input clocks later, the block captures the clock-mode straps and enables the PLL. Hard reset stays asserted until the PLL reports lock, the external bus reset is released and no software hard-reset request is pending. A software soft-reset request acts on soft reset alone.

When hard reset is released and the subsystem is the configuration master, the block fetches a short run of 64-bit words from boot memory. It uses a valid/ready request channel and a response-valid data channel, and keeps the first word as the hard configuration word. When the subsystem is not the master, a default word is loaded and no fetch is made. Soft reset is released only once the configuration word is in place, and a done flag pulses for one cycle at that point. A loss of power-good restarts everything from the power-on state.

Top module: `rst_hier_seq`

## Requirements
- R1: Power-on reset low forces hard and soft reset low. Hard reset low forces soft reset low. A soft request leaves power-on and hard reset high.
- R2: `por_n_o` stays low while `pwr_good_i` is low. It rises after the PWR_HOLD_CYC-th consecutive clock edge with `pwr_good_i` high.
- R3: On the STRAP_WAIT_CYC-th clock edge after `por_n_o` rises, `mode_strap_i` is captured into `mode_o` and `pll_en_o` rises. Both then hold.
- R4: `hrst_n_o` rises on the edge after all of these hold together: `pll_en_o`, `pll_lock_i` and `bus_rst_n_i` high and `db_hard_i` low. While `pll_lock_i` is low, `hrst_n_o` is low from the next edge on.
- R5: While the active-low `bus_rst_n_i` is low, `hrst_n_o` is low from the next edge on.
- R6: `db_hard_i` high drives `hrst_n_o` and `srst_n_o` low from the next edge on. `db_soft_i` high drives only `srst_n_o` low, in the same cycle.
- R7: After hard reset is released with `cfg_master_i` high, the block issues CFG_READS reads, one at a time, to byte addresses 0, 8, 16 and so on. Each request holds valid and address until ready, and the block waits without limit for each response.
- R8: The data of the response to address 0 appears on `cfg_word_o`.
- R9: With `cfg_master_i` low at hard reset release, no request is issued and `cfg_word_o` takes DEFAULT_CFG.
- R10: `srst_n_o` stays low until the configuration word is latched. `seq_done_o` is high for exactly one cycle, the first cycle in which `srst_n_o` may be high.
- R11: `pwr_good_i` low on an edge clears all resets, `pll_en_o`, `mode_o`, `cfg_word_o` and the fetch from that edge on. The whole sequence then restarts.
- R12: After `rst`, all reset outputs are low and `pll_en_o`, `mode_o`, `cfg_word_o`, `rd_req_valid_o` and `seq_done_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supervisor power-good |
| pll_lock_i | input | 1 | PLL lock flag |
| bus_rst_n_i | input | 1 | External bus reset, active low |
| db_hard_i | input | 1 | Software hard-reset request |
| db_soft_i | input | 1 | Software soft-reset request |
| cfg_master_i | input | 1 | Fetch configuration from boot memory when high |
| mode_strap_i | input | MODE_W | Clock-mode strap pins |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request ready |
| rd_req_addr_o | output | 32 | Read byte address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | DATA_W | Read response data |
| por_n_o | output | 1 | Power-on reset, active low |
| hrst_n_o | output | 1 | Hard reset, active low |
| srst_n_o | output | 1 | Soft reset, active low |
| pll_en_o | output | 1 | PLL enable |
| mode_o | output | MODE_W | Captured clock mode |
| cfg_word_o | output | DATA_W | Hard configuration word |
| seq_done_o | output | 1 | One-cycle sequence-complete pulse |

## Verification
The bench moves the straps one cycle before the capture edge. A sampler that is off by one clock would record the earlier strap value or raise the PLL enable a cycle early. The memory model stalls ready and delays responses, so a fetch that drops a request, moves its address or takes a stale response would log the wrong address sequence or latch the wrong word. A table of lock, bus-reset and doorbell combinations probes the reset hierarchy: a soft request that leaks into hard reset, or a gate that is ignored, shows up on the outputs. A power drop in the middle of a fetch checks that the straps, PLL enable and configuration word are really cleared, rather than surviving into the restarted sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int unsigned BOOT_ADDR_W = 32;
    localparam int unsigned BOOT_STRIDE = 8;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_WAIT,
        F_DONE
    } fetch_st_e;

    // Every condition that must hold before hard reset may be released.
    typedef struct packed {
        logic por_released;
        logic straps_done;
        logic pll_locked;
        logic bus_free;
        logic no_sw_hard;
    } hard_gate_t;

    function automatic logic hard_release_ok(hard_gate_t g);
        return &g;
    endfunction

    function automatic logic [BOOT_ADDR_W-1:0] boot_addr(int unsigned idx);
        return BOOT_ADDR_W'(idx * BOOT_STRIDE);
    endfunction

endpackage

// File: rtl/rst_por_stretch.sv
module rst_por_stretch #(
    parameter int unsigned HOLD_CYC = 9_900_000
) (
    input  logic clk,
    input  logic clr,
    output logic por_rel_o
);
    localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt       <= '0;
            por_rel_o <= 1'b0;
        end else if (!por_rel_o) begin
            if (cnt == CW'(HOLD_CYC - 1)) por_rel_o <= 1'b1;
            else                          cnt       <= cnt + 1'b1;
        end
    end

    AST_POR_STAYS_RELEASED: assert property (@(posedge clk) disable iff (clr)
        por_rel_o |=> por_rel_o); // R2
endmodule

// File: rtl/rst_strap_cap.sv
module rst_strap_cap #(
    parameter int unsigned WAIT_CYC = 1024,
    parameter int unsigned MODE_W   = 3
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              por_rel_i,
    input  logic [MODE_W-1:0] strap_i,
    output logic              pll_en_o,
    output logic [MODE_W-1:0] mode_o
);
    localparam int unsigned CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt      <= '0;
            pll_en_o <= 1'b0;
            mode_o   <= '0;
        end else if (por_rel_i && !pll_en_o) begin
            if (cnt == CW'(WAIT_CYC - 1)) begin
                pll_en_o <= 1'b1;
                mode_o   <= strap_i;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_PLL_AFTER_POR: assert property (@(posedge clk) disable iff (clr)
        $rose(pll_en_o) |-> $past(por_rel_i)); // R3
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (clr)
        (pll_en_o && $past(pll_en_o)) |-> $stable(mode_o)); // R3
endmodule

// File: rtl/rst_cfg_fetch.sv
module rst_cfg_fetch
    import rst_seq_pkg::*;
#(
    parameter int unsigned     CFG_READS   = 4,
    parameter int unsigned     DATA_W      = 64,
    parameter logic [DATA_W-1:0] DEFAULT_CFG = '0
) (
    input  logic                   clk,
    input  logic                   clr,
    input  logic                   en_i,
    input  logic                   master_i,
    output logic                   req_valid_o,
    input  logic                   req_ready_i,
    output logic [BOOT_ADDR_W-1:0] req_addr_o,
    input  logic                   rsp_valid_i,
    input  logic [DATA_W-1:0]      rsp_data_i,
    output logic [DATA_W-1:0]      cfg_word_o,
    output logic                   fin_o
);
    localparam int unsigned IDX_W = (CFG_READS > 1) ? $clog2(CFG_READS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_READS - 1);

    fetch_st_e      st;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (clr) begin
            st         <= F_IDLE;
            idx        <= '0;
            cfg_word_o <= '0;
        end else if (!en_i) begin
            st  <= F_IDLE;
            idx <= '0;
        end else begin
            case (st)
                F_IDLE: begin
                    if (master_i) begin
                        st <= F_REQ;
                    end else begin
                        cfg_word_o <= DEFAULT_CFG;
                        st         <= F_DONE;
                    end
                end
                F_REQ: if (req_ready_i) st <= F_WAIT;
                F_WAIT: begin
                    if (rsp_valid_i) begin
                        if (idx == '0) cfg_word_o <= rsp_data_i;
                        if (idx == LAST_IDX) begin
                            st <= F_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= F_REQ;
                        end
                    end
                end
                default: st <= F_DONE;
            endcase
        end
    end

    assign req_valid_o = (st == F_REQ);
    assign req_addr_o  = boot_addr(int'(idx));
    assign fin_o       = (st == F_DONE);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (clr || !en_i)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o))); // R7
    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (clr)
        !en_i |=> !req_valid_o); // R7
endmodule

// File: rtl/rst_hier_seq.sv
module rst_hier_seq
    import rst_seq_pkg::*;
#(
    parameter int unsigned       PWR_HOLD_CYC   = 9_900_000, // 150 ms at 66 MHz
    parameter int unsigned       STRAP_WAIT_CYC = 1024,
    parameter int unsigned       MODE_W         = 3,
    parameter int unsigned       CFG_READS      = 4,
    parameter int unsigned       DATA_W         = 64,
    parameter logic [DATA_W-1:0] DEFAULT_CFG    = 64'h0000_0000_0000_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pwr_good_i,
    input  logic                   pll_lock_i,
    input  logic                   bus_rst_n_i,
    input  logic                   db_hard_i,
    input  logic                   db_soft_i,
    input  logic                   cfg_master_i,
    input  logic [MODE_W-1:0]      mode_strap_i,
    output logic                   rd_req_valid_o,
    input  logic                   rd_req_ready_i,
    output logic [BOOT_ADDR_W-1:0] rd_req_addr_o,
    input  logic                   rd_rsp_valid_i,
    input  logic [DATA_W-1:0]      rd_rsp_data_i,
    output logic                   por_n_o,
    output logic                   hrst_n_o,
    output logic                   srst_n_o,
    output logic                   pll_en_o,
    output logic [MODE_W-1:0]      mode_o,
    output logic [DATA_W-1:0]      cfg_word_o,
    output logic                   seq_done_o
);
    logic       clr;
    logic       por_rel;
    logic       hrst_n_q;
    logic       fin;
    logic       fin_d;
    hard_gate_t gate;

    assign clr = rst || !pwr_good_i;

    rst_por_stretch #(.HOLD_CYC(PWR_HOLD_CYC)) u_por (
        .clk(clk), .clr(clr), .por_rel_o(por_rel)
    );

    rst_strap_cap #(.WAIT_CYC(STRAP_WAIT_CYC), .MODE_W(MODE_W)) u_strap (
        .clk(clk), .clr(clr), .por_rel_i(por_rel), .strap_i(mode_strap_i),
        .pll_en_o(pll_en_o), .mode_o(mode_o)
    );

    always_comb begin
        gate.por_released = por_rel;
        gate.straps_done  = pll_en_o;
        gate.pll_locked   = pll_lock_i;
        gate.bus_free     = bus_rst_n_i;
        gate.no_sw_hard   = !db_hard_i;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            hrst_n_q <= 1'b0;
            fin_d    <= 1'b0;
        end else begin
            hrst_n_q <= hard_release_ok(gate);
            fin_d    <= fin;
        end
    end

    rst_cfg_fetch #(.CFG_READS(CFG_READS), .DATA_W(DATA_W), .DEFAULT_CFG(DEFAULT_CFG)) u_fetch (
        .clk(clk), .clr(clr), .en_i(hrst_n_q), .master_i(cfg_master_i),
        .req_valid_o(rd_req_valid_o), .req_ready_i(rd_req_ready_i),
        .req_addr_o(rd_req_addr_o), .rsp_valid_i(rd_rsp_valid_i),
        .rsp_data_i(rd_rsp_data_i), .cfg_word_o(cfg_word_o), .fin_o(fin)
    );

    assign por_n_o    = por_rel;
    assign hrst_n_o   = hrst_n_q;
    assign srst_n_o   = hrst_n_q && fin && !db_soft_i;
    assign seq_done_o = fin && !fin_d;

    AST_POR_FORCES_HARD: assert property (@(posedge clk) disable iff (rst)
        !por_n_o |-> !hrst_n_o); // R1
    AST_HARD_FORCES_SOFT: assert property (@(posedge clk) disable iff (rst)
        !hrst_n_o |-> !srst_n_o); // R1
    AST_LOCK_GATES_HARD: assert property (@(posedge clk) disable iff (clr)
        !pll_lock_i |=> !hrst_n_o); // R4
    AST_BUS_GATES_HARD: assert property (@(posedge clk) disable iff (clr)
        !bus_rst_n_i |=> !hrst_n_o); // R5
    AST_SW_HARD: assert property (@(posedge clk) disable iff (clr)
        db_hard_i |=> (!hrst_n_o && !srst_n_o)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (clr)
        seq_done_o |=> !seq_done_o); // R10
    AST_PWR_LOSS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !pwr_good_i |=> (!por_n_o && !pll_en_o && mode_o == '0)); // R11
endmodule

// File: tb/tb_rst_hier_seq.sv
`timescale 1ns/1ps
module tb_rst_hier_seq;
    localparam int unsigned HOLD   = 20;
    localparam int unsigned SWAIT  = 1024;
    localparam int unsigned NREAD  = 4;
    localparam logic [63:0] DEFCFG = 64'hD00D_FEED_0000_0003;

    logic        clk = 1'b0;
    logic        rst, pwr_good, pll_lock, bus_rst_n, db_hard, db_soft, cfg_master;
    logic [2:0]  strap;
    logic        req_valid, req_ready, rsp_valid;
    logic [31:0] req_addr;
    logic [63:0] rsp_data;
    logic        por_n, hrst_n, srst_n, pll_en, done;
    logic [2:0]  mode;
    logic [63:0] cfg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rst_hier_seq #(
        .PWR_HOLD_CYC(HOLD), .STRAP_WAIT_CYC(SWAIT), .MODE_W(3),
        .CFG_READS(NREAD), .DATA_W(64), .DEFAULT_CFG(DEFCFG)
    ) dut (
        .clk(clk), .rst(rst), .pwr_good_i(pwr_good), .pll_lock_i(pll_lock),
        .bus_rst_n_i(bus_rst_n), .db_hard_i(db_hard), .db_soft_i(db_soft),
        .cfg_master_i(cfg_master), .mode_strap_i(strap),
        .rd_req_valid_o(req_valid), .rd_req_ready_i(req_ready), .rd_req_addr_o(req_addr),
        .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data),
        .por_n_o(por_n), .hrst_n_o(hrst_n), .srst_n_o(srst_n), .pll_en_o(pll_en),
        .mode_o(mode), .cfg_word_o(cfg), .seq_done_o(done)
    );

    function automatic logic [63:0] memval(logic [31:0] a);
        return 64'hA5C3_0F1E_0000_0000 | {32'h0, a} | 64'h0000_0000_0100_0000;
    endfunction

    // Boot memory model: stalls ready between requests, answers after mem_lat cycles.
    int          mem_lat = 0;
    int          mem_stall = 0;
    int          stall_left = 0;
    int          lat_left = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          n_req = 0;
    logic [31:0] addr_log [8];

    initial begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
    end

    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (pend) begin
            if (lat_left == 0) begin
                rsp_valid = 1'b1;
                rsp_data  = memval(pend_addr);
                pend      = 1'b0;
            end else begin
                lat_left--;
            end
        end
        req_ready = (stall_left == 0);
        if (stall_left > 0) stall_left--;
        if (req_valid && req_ready) begin
            if (n_req < 8) addr_log[n_req] = req_addr;
            n_req++;
            pend       = 1'b1;
            pend_addr  = req_addr;
            lat_left   = mem_lat;
            stall_left = mem_stall;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs until soft reset releases; checks the done pulse against the release.
    int pulses;
    task automatic run_to_done(string req);
        pulses = 0;
        for (int i = 0; i < 400; i++) begin
            tick();
            if (done) begin
                pulses++;
                check({req, " R10 srst released with done"}, {63'd0, srst_n}, 64'd1);
            end
            if (srst_n) break;
        end
        check({req, " R10 srst released"}, {63'd0, srst_n}, 64'd1);
        tick();
        if (done) pulses++;
        check({req, " R10 done pulse count"}, 64'(pulses), 64'd1);
    endtask

    localparam logic [5:0] VEC [8] = '{
        6'b1101_10, 6'b1110_00, 6'b0100_00, 6'b1000_00,
        6'b1100_11, 6'b0001_00, 6'b1011_00, 6'b1111_00
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pwr_good = 1'b0; pll_lock = 1'b0; bus_rst_n = 1'b1;
        db_hard = 1'b0; db_soft = 1'b0; cfg_master = 1'b1; strap = 3'b000;
        @(negedge clk);
        repeat (3) tick();
        // R12 reset state
        check("R12 por_n", {63'd0, por_n}, 64'd0);
        check("R12 hrst_n", {63'd0, hrst_n}, 64'd0);
        check("R12 srst_n", {63'd0, srst_n}, 64'd0);
        check("R12 pll_en/mode", {60'd0, pll_en, mode}, 64'd0);
        check("R12 cfg", cfg, 64'd0);
        check("R12 req/done", {62'd0, req_valid, done}, 64'd0);

        rst = 1'b0;
        repeat (5) tick();
        check("R2 por held while power bad", {63'd0, por_n}, 64'd0);

        pwr_good = 1'b1;
        repeat (HOLD - 1) tick();
        check("R2 por before hold end", {63'd0, por_n}, 64'd0);
        tick();
        check("R2 por released at hold end", {63'd0, por_n}, 64'd1);

        strap = 3'b101;
        repeat (SWAIT - 1) tick();
        check("R3 pll_en before strap edge", {63'd0, pll_en}, 64'd0);
        strap = 3'b110;
        tick();
        check("R3 pll_en at strap edge", {63'd0, pll_en}, 64'd1);
        check("R3 strap captured", {61'd0, mode}, 64'd6);
        strap = 3'b000;
        tick();
        check("R3 mode held", {61'd0, mode}, 64'd6);

        repeat (5) tick();
        check("R4 hard held without lock", {63'd0, hrst_n}, 64'd0);
        pll_lock = 1'b1; bus_rst_n = 1'b0;
        repeat (5) tick();
        check("R5 hard held by bus reset", {63'd0, hrst_n}, 64'd0);
        mem_lat = 3; mem_stall = 2;
        bus_rst_n = 1'b1;
        tick();
        check("R4 hard released", {63'd0, hrst_n}, 64'd1);
        check("R10 soft held during fetch", {63'd0, srst_n}, 64'd0);
        run_to_done("first fetch");
        check("R7 read count", 64'(n_req), 64'(NREAD));
        for (int i = 0; i < int'(NREAD); i++)
            check("R7 read address", {32'd0, addr_log[i]}, 64'(i * 8));
        check("R8 cfg word", cfg, memval(32'd0));

        // Reset hierarchy table: {lock, bus_n, db_hard, db_soft, exp_hrst_n, exp_srst_n}
        for (int v = 0; v < 8; v++) begin
            {pll_lock, bus_rst_n, db_hard, db_soft} = VEC[v][5:2];
            tick();
            check("R1/R4/R5/R6 table hrst_n", {63'd0, hrst_n}, {63'd0, VEC[v][1]});
            check("R1/R6 table srst_n", {63'd0, srst_n}, {63'd0, VEC[v][0]});
            check("R1 table por_n", {63'd0, por_n}, 64'd1);
            pll_lock = 1'b1; bus_rst_n = 1'b1; db_hard = 1'b0; db_soft = 1'b0;
            for (int i = 0; i < 200 && !srst_n; i++) tick();
            check("R8 cfg kept after table step", cfg, memval(32'd0));
        end

        // R9: not configuration master
        db_hard = 1'b1;
        tick();
        check("R6 sw hard drops hard", {63'd0, hrst_n}, 64'd0);
        check("R6 sw hard drops soft", {63'd0, srst_n}, 64'd0);
        cfg_master = 1'b0;
        n_req = 0;
        db_hard = 1'b0;
        run_to_done("R9 default");
        check("R9 default cfg", cfg, DEFCFG);
        check("R9 no requests", 64'(n_req), 64'd0);

        // R11: power loss mid-fetch
        cfg_master = 1'b1; mem_lat = 6;
        db_hard = 1'b1;
        tick();
        db_hard = 1'b0;
        repeat (4) tick();
        pwr_good = 1'b0;
        tick();
        check("R11 por asserted", {63'd0, por_n}, 64'd0);
        check("R11 hard/soft asserted", {62'd0, hrst_n, srst_n}, 64'd0);
        check("R11 pll_en/mode cleared", {60'd0, pll_en, mode}, 64'd0);
        check("R11 cfg cleared", cfg, 64'd0);
        check("R11 no request", {63'd0, req_valid}, 64'd0);
        pwr_good = 1'b1;
        repeat (HOLD - 1) tick();
        check("R11 restart por still held", {63'd0, por_n}, 64'd0);
        tick();
        check("R11 restart por released", {63'd0, por_n}, 64'd1);
        check("R11 restart pll_en low", {63'd0, pll_en}, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule